// File: doc/BRIEF.md
# Delay-Slot Hazard Scoreboard

This block watches the stream of operation packets that a wide-issue datapath sends out, one packet per clock, and flags every breach of the pipeline timing rules. A packet carries up to eight operations. Each operation gives its class, one destination register, two source registers and the functional unit that executes it. The block does not execute anything and does not stall anything. It only reports when a source is read before the result of an earlier operation is ready, when an operation is sent to a unit that is still busy, when two operations in one packet write the same register or use the same unit, and when a packet makes too many reads across the two register banks.

Two sets of countdown timers hold the state. One timer per register counts the delay slots still pending on that register. One timer per functional unit counts the cycles for which that unit is still held. The two are kept apart because a double-precision multiply holds its multiplier for 4 cycles, but its result is not ready until 9 delay slots have passed. All hazard outputs are registered, so each one describes the packet that was presented in the cycle before.

Register index encoding: bit 4 selects the bank (0 = bank A, 1 = bank B) and bits 3:0 select one of the 16 registers in that bank. Unit index encoding: bit 2 selects the side (0 = A, 1 = B) and bits 1:0 select one of the four units on that side.

Top module: `hz_scoreboard`

## Requirements
- R1: After reset, and after any later reset, every hazard output is 0, every register counts as ready and every unit counts as free.
- R2: A single-cycle operation (class code 0) that writes a register lets any later packet read that register without a flag.
- R3: A multiply (class code 1) has one delay slot. A read of its destination in the next packet raises haz_early_read. A read two packets after issue does not.
- R4: A load (class code 2) has 4 delay slots and a branch (class code 3) has 5. A read k packets after issue is flagged when k is at most the slot count and is not flagged after that.
- R5: A double-precision multiply (class code 5) has 9 delay slots. Reads 1 to 9 packets after issue are flagged and a read 10 packets after issue is not.
- R6: A store (class code 4) leaves no register pending, even when its destination enable is set. Two stores that name the same destination never raise haz_dual_write.
- R7: A double-precision multiply holds its unit for its issue cycle and the 3 cycles after it, so any issue to that unit 1 to 3 packets later raises haz_unit_busy with that unit on busy_unit. Every other class frees its unit for the next packet, and a later short operation does not shorten a hold that is still running.
- R8: Two valid operations in one packet that name the same unit raise haz_unit_clash, and clash_unit gives that unit.
- R9: A source read is a cross-bank read when the bank bit of the register differs from the side bit of the unit. A packet with more than 2 such reads raises haz_cross_limit. A packet with 2 or fewer does not.
- R10: Two register-writing operations in one packet with the same destination raise haz_dual_write. dual_reg gives the destination of the lowest lane that repeats the destination of an earlier lane.
- R11: Every flag and reported index appears in the cycle after its packet. early_reg gives the register of the lowest offending lane, with source 0 checked before source 1. busy_unit gives the unit of the lowest offending lane.
- R12: A read in the same packet as the operation that writes that register is not flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_vld | input | 8 | Per-lane operation valid |
| op_cls | input | 24 | Per-lane class code, 3 bits per lane |
| op_dst | input | 40 | Per-lane destination register, 5 bits per lane |
| op_dst_en | input | 8 | Per-lane destination write enable |
| op_src0 | input | 40 | Per-lane first source register |
| op_src0_en | input | 8 | Per-lane first source used |
| op_src1 | input | 40 | Per-lane second source register |
| op_src1_en | input | 8 | Per-lane second source used |
| op_unit | input | 24 | Per-lane functional unit, 3 bits per lane |
| haz_early_read | output | 1 | A source was read before its delay slots elapsed |
| early_reg | output | 5 | Register of the first early read |
| haz_unit_busy | output | 1 | An operation was issued to a held unit |
| busy_unit | output | 3 | Unit of the first busy issue |
| haz_unit_clash | output | 1 | Two operations in the packet use one unit |
| clash_unit | output | 3 | Unit named twice |
| haz_dual_write | output | 1 | Two writes to one register in the packet |
| dual_reg | output | 5 | Register written twice |
| haz_cross_limit | output | 1 | More cross-bank reads than allowed |

## Verification
The properties assume that reset holds the inputs idle, and that a lane-0 operation in the packet after a multiply or a double-precision multiply is the reader or the re-issuer being checked. They treat each flag as the consequence of a packet that the property itself describes. The bench keeps every sweep case apart. It waits more idle packets than the longest delay or hold before the next case, so no timer left by one case can reach into another. It also gives readers units on the same side as the register they read, except in the cross-bank cases, and gives every lane its own unit, except where a clash is the point.

// File: rtl/hz_pkg.sv
// Package: class codes and per-class timing for the hazard scoreboard.
// Assumes class codes 6 and 7 are unused and treats them as single-cycle.
package hz_pkg;

    localparam int DLY_W  = 4;   // wide enough for 9 delay slots
    localparam int HOLD_W = 2;   // wide enough for 3 extra hold cycles

    typedef enum logic [2:0] {
        OPC_ALU    = 3'd0,
        OPC_MUL    = 3'd1,
        OPC_LOAD   = 3'd2,
        OPC_BRANCH = 3'd3,
        OPC_STORE  = 3'd4,
        OPC_DPMUL  = 3'd5
    } op_class_e;

    // Number of delay slots before the result of a class may be read.
    function automatic logic [DLY_W-1:0] result_delay(input logic [2:0] cls);
        case (op_class_e'(cls))
            OPC_MUL:    return DLY_W'(1);
            OPC_LOAD:   return DLY_W'(4);
            OPC_BRANCH: return DLY_W'(5);
            OPC_DPMUL:  return DLY_W'(9);
            default:    return DLY_W'(0);
        endcase
    endfunction

    // Cycles a class holds its unit beyond the issue cycle.
    function automatic logic [HOLD_W-1:0] unit_hold(input logic [2:0] cls);
        return (op_class_e'(cls) == OPC_DPMUL) ? HOLD_W'(3) : HOLD_W'(0);
    endfunction

    // Whether a class produces a register result that the timers track.
    function automatic logic writes_reg(input logic [2:0] cls);
        return op_class_e'(cls) != OPC_STORE;
    endfunction

endpackage

// File: rtl/hz_slot_timer.sv
// Per-register delay-slot countdown.
// A write loads the delay-slot count of its class; the count then falls by
// one per cycle. A register is pending while its count is nonzero.
// Assumes at most one meaningful writer per register per cycle; if several
// lanes write one register the highest lane's delay is kept.
module hz_slot_timer #(
    parameter int LANES = 8,
    parameter int REG_W = 5,
    parameter int DLY_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         wr_vld,
    input  logic [LANES*REG_W-1:0]   wr_reg,
    input  logic [LANES*DLY_W-1:0]   wr_dly,
    output logic [(2**REG_W)-1:0]    pending
);

    localparam int NREG = 2**REG_W;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic             hit;
        logic [DLY_W-1:0] load_val;
        logic [DLY_W-1:0] cnt;

        // Find a lane that writes this register in the current packet.
        always_comb begin
            hit      = 1'b0;
            load_val = '0;
            for (int l = 0; l < LANES; l++) begin
                if (wr_vld[l] && (wr_reg[l*REG_W +: REG_W] == REG_W'(r))) begin
                    hit      = 1'b1;
                    load_val = wr_dly[l*DLY_W +: DLY_W];
                end
            end
        end

        // Load on write, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (hit) begin
                cnt <= load_val;
            end else if (cnt != '0) begin
                cnt <= cnt - DLY_W'(1);
            end
        end

        assign pending[r] = (cnt != '0);
    end

endmodule

// File: rtl/hz_unit_timer.sv
// Per-unit occupancy countdown.
// An issue loads the extra hold cycles of its class. The unit is busy while
// the count is nonzero. A new issue never shortens a hold that is still running.
module hz_unit_timer #(
    parameter int LANES  = 8,
    parameter int UNIT_W = 3,
    parameter int HOLD_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         iss_vld,
    input  logic [LANES*UNIT_W-1:0]  iss_unit,
    input  logic [LANES*HOLD_W-1:0]  iss_hold,
    output logic [(2**UNIT_W)-1:0]   busy
);

    localparam int NUNIT = 2**UNIT_W;

    for (genvar u = 0; u < NUNIT; u++) begin : g_unit
        logic              hit;
        logic [HOLD_W-1:0] load_val;
        logic [HOLD_W-1:0] dec;
        logic [HOLD_W-1:0] cnt;

        // Collect the longest hold requested for this unit this cycle.
        always_comb begin
            hit      = 1'b0;
            load_val = '0;
            for (int l = 0; l < LANES; l++) begin
                if (iss_vld[l] && (iss_unit[l*UNIT_W +: UNIT_W] == UNIT_W'(u))) begin
                    hit = 1'b1;
                    if (iss_hold[l*HOLD_W +: HOLD_W] > load_val) begin
                        load_val = iss_hold[l*HOLD_W +: HOLD_W];
                    end
                end
            end
        end

        assign dec = (cnt != '0) ? cnt - HOLD_W'(1) : '0;

        // Keep the larger of the running hold and a new request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt <= '0;
            end else if (hit && (load_val > dec)) begin
                cnt <= load_val;
            end else begin
                cnt <= dec;
            end
        end

        assign busy[u] = (cnt != '0);
    end

endmodule

// File: rtl/hz_packet_check.sv
// Checks inside one packet: two writes to one register, two operations on
// one unit, and the number of cross-bank source reads.
// Purely combinational; assumes the write vector already excludes stores.
module hz_packet_check #(
    parameter int LANES     = 8,
    parameter int REG_W     = 5,
    parameter int UNIT_W    = 3,
    parameter int XPATH_MAX = 2
) (
    input  logic [LANES-1:0]         vld,
    input  logic [LANES-1:0]         wr,
    input  logic [LANES*REG_W-1:0]   dst,
    input  logic [LANES*UNIT_W-1:0]  unit,
    input  logic [LANES*REG_W-1:0]   src0,
    input  logic [LANES-1:0]         src0_en,
    input  logic [LANES*REG_W-1:0]   src1,
    input  logic [LANES-1:0]         src1_en,
    output logic                     dual_hit,
    output logic [REG_W-1:0]         dual_reg,
    output logic                     clash_hit,
    output logic [UNIT_W-1:0]        clash_unit,
    output logic                     cross_over
);

    localparam int XCNT_W = $clog2(2*LANES + 1);

    logic [XCNT_W-1:0] xcnt;

    // Two writes to one register; the lowest repeating lane is reported.
    always_comb begin
        dual_hit = 1'b0;
        dual_reg = '0;
        for (int j = LANES-1; j >= 1; j--) begin
            for (int i = 0; i < LANES; i++) begin
                if ((i < j) && wr[i] && wr[j] &&
                    (dst[i*REG_W +: REG_W] == dst[j*REG_W +: REG_W])) begin
                    dual_hit = 1'b1;
                    dual_reg = dst[j*REG_W +: REG_W];
                end
            end
        end
    end

    // Two operations on one unit; the lowest repeating lane is reported.
    always_comb begin
        clash_hit  = 1'b0;
        clash_unit = '0;
        for (int j = LANES-1; j >= 1; j--) begin
            for (int i = 0; i < LANES; i++) begin
                if ((i < j) && vld[i] && vld[j] &&
                    (unit[i*UNIT_W +: UNIT_W] == unit[j*UNIT_W +: UNIT_W])) begin
                    clash_hit  = 1'b1;
                    clash_unit = unit[j*UNIT_W +: UNIT_W];
                end
            end
        end
    end

    // Count source reads whose bank differs from the unit's side.
    always_comb begin
        xcnt = '0;
        for (int l = 0; l < LANES; l++) begin
            if (vld[l] && src0_en[l] &&
                (src0[l*REG_W + REG_W-1] != unit[l*UNIT_W + UNIT_W-1])) begin
                xcnt = xcnt + XCNT_W'(1);
            end
            if (vld[l] && src1_en[l] &&
                (src1[l*REG_W + REG_W-1] != unit[l*UNIT_W + UNIT_W-1])) begin
                xcnt = xcnt + XCNT_W'(1);
            end
        end
    end

    assign cross_over = (xcnt > XCNT_W'(XPATH_MAX));

endmodule

// File: rtl/hz_scoreboard.sv
// Top of the delay-slot hazard scoreboard.
// Decodes each lane's class into delay slots and unit hold, feeds the register
// and unit timers, runs the packet checks, and registers all flags one cycle
// after the packet. Assumes one packet per cycle and that the register index
// MSB is the bank and the unit index MSB is the side.
module hz_scoreboard #(
    parameter int LANES      = 8,
    parameter int BANK_REGS  = 16,
    parameter int SIDE_UNITS = 4,
    parameter int XPATH_MAX  = 2,
    localparam int REG_W     = 1 + $clog2(BANK_REGS),
    localparam int UNIT_W    = 1 + $clog2(SIDE_UNITS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         op_vld,
    input  logic [LANES*3-1:0]       op_cls,
    input  logic [LANES*REG_W-1:0]   op_dst,
    input  logic [LANES-1:0]         op_dst_en,
    input  logic [LANES*REG_W-1:0]   op_src0,
    input  logic [LANES-1:0]         op_src0_en,
    input  logic [LANES*REG_W-1:0]   op_src1,
    input  logic [LANES-1:0]         op_src1_en,
    input  logic [LANES*UNIT_W-1:0]  op_unit,
    output logic                     haz_early_read,
    output logic [REG_W-1:0]         early_reg,
    output logic                     haz_unit_busy,
    output logic [UNIT_W-1:0]        busy_unit,
    output logic                     haz_unit_clash,
    output logic [UNIT_W-1:0]        clash_unit,
    output logic                     haz_dual_write,
    output logic [REG_W-1:0]         dual_reg,
    output logic                     haz_cross_limit
);

    import hz_pkg::*;

    localparam int NREG  = 2**REG_W;
    localparam int NUNIT = 2**UNIT_W;

    logic [LANES-1:0]          wr_vld;
    logic [LANES*DLY_W-1:0]    wr_dly;
    logic [LANES*HOLD_W-1:0]   iss_hold;
    logic [NREG-1:0]           pending;
    logic [NUNIT-1:0]          busy;

    logic                      early_c;
    logic [REG_W-1:0]          early_reg_c;
    logic                      busy_c;
    logic [UNIT_W-1:0]         busy_unit_c;
    logic                      dual_c;
    logic [REG_W-1:0]          dual_reg_c;
    logic                      clash_c;
    logic [UNIT_W-1:0]         clash_unit_c;
    logic                      cross_c;

    // Per-lane class decode into write enable, delay slots and unit hold.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign wr_vld[l] = op_vld[l] && op_dst_en[l] && writes_reg(op_cls[l*3 +: 3]);
        assign wr_dly[l*DLY_W +: DLY_W]    = result_delay(op_cls[l*3 +: 3]);
        assign iss_hold[l*HOLD_W +: HOLD_W] = unit_hold(op_cls[l*3 +: 3]);
    end

    hz_slot_timer #(
        .LANES (LANES),
        .REG_W (REG_W),
        .DLY_W (DLY_W)
    ) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_vld  (wr_vld),
        .wr_reg  (op_dst),
        .wr_dly  (wr_dly),
        .pending (pending)
    );

    hz_unit_timer #(
        .LANES  (LANES),
        .UNIT_W (UNIT_W),
        .HOLD_W (HOLD_W)
    ) u_units (
        .clk      (clk),
        .rst_n    (rst_n),
        .iss_vld  (op_vld),
        .iss_unit (op_unit),
        .iss_hold (iss_hold),
        .busy     (busy)
    );

    hz_packet_check #(
        .LANES     (LANES),
        .REG_W     (REG_W),
        .UNIT_W    (UNIT_W),
        .XPATH_MAX (XPATH_MAX)
    ) u_pkt (
        .vld        (op_vld),
        .wr         (wr_vld),
        .dst        (op_dst),
        .unit       (op_unit),
        .src0       (op_src0),
        .src0_en    (op_src0_en),
        .src1       (op_src1),
        .src1_en    (op_src1_en),
        .dual_hit   (dual_c),
        .dual_reg   (dual_reg_c),
        .clash_hit  (clash_c),
        .clash_unit (clash_unit_c),
        .cross_over (cross_c)
    );

    // Early reads against pending registers; lowest lane, source 0 first.
    always_comb begin
        early_c     = 1'b0;
        early_reg_c = '0;
        for (int l = LANES-1; l >= 0; l--) begin
            if (op_vld[l] && op_src1_en[l] && pending[op_src1[l*REG_W +: REG_W]]) begin
                early_c     = 1'b1;
                early_reg_c = op_src1[l*REG_W +: REG_W];
            end
            if (op_vld[l] && op_src0_en[l] && pending[op_src0[l*REG_W +: REG_W]]) begin
                early_c     = 1'b1;
                early_reg_c = op_src0[l*REG_W +: REG_W];
            end
        end
    end

    // Issues to held units; lowest lane reported.
    always_comb begin
        busy_c      = 1'b0;
        busy_unit_c = '0;
        for (int l = LANES-1; l >= 0; l--) begin
            if (op_vld[l] && busy[op_unit[l*UNIT_W +: UNIT_W]]) begin
                busy_c      = 1'b1;
                busy_unit_c = op_unit[l*UNIT_W +: UNIT_W];
            end
        end
    end

    // Register every flag and index for the cycle after the packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            haz_early_read  <= 1'b0;
            early_reg       <= '0;
            haz_unit_busy   <= 1'b0;
            busy_unit       <= '0;
            haz_unit_clash  <= 1'b0;
            clash_unit      <= '0;
            haz_dual_write  <= 1'b0;
            dual_reg        <= '0;
            haz_cross_limit <= 1'b0;
        end else begin
            haz_early_read  <= early_c;
            early_reg       <= early_reg_c;
            haz_unit_busy   <= busy_c;
            busy_unit       <= busy_unit_c;
            haz_unit_clash  <= clash_c;
            clash_unit      <= clash_unit_c;
            haz_dual_write  <= dual_c;
            dual_reg        <= dual_reg_c;
            haz_cross_limit <= cross_c;
        end
    end

endmodule

// File: rtl/hz_scoreboard_sva.sv
// Checker for hz_scoreboard, attached by bind. Looks at lanes 0 to 2 only,
// so it needs LANES >= 3.
module hz_scoreboard_sva #(
    parameter int LANES  = 8,
    parameter int REG_W  = 5,
    parameter int UNIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  vld,
    input  logic [2:0]        cls0,
    input  logic [2:0]        cls1,
    input  logic [REG_W-1:0]  dst0,
    input  logic [REG_W-1:0]  dst1,
    input  logic [1:0]        den,
    input  logic [REG_W-1:0]  src0_l0,
    input  logic [2:0]        s_en,
    input  logic [2:0]        src_bank,
    input  logic [UNIT_W-1:0] unit0,
    input  logic [2:0]        unit_side,
    input  logic              haz_early_read,
    input  logic              haz_unit_busy,
    input  logic              haz_unit_clash,
    input  logic              haz_dual_write,
    input  logic              haz_cross_limit
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (vld == '0) |=> !(haz_early_read || haz_unit_busy || haz_unit_clash || haz_dual_write || haz_cross_limit)); // R11

    AST_MUL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(vld[0] && cls0 == 3'd1 && den[0]) && vld[0] && s_en[0] && src0_l0 == $past(dst0))
        |=> haz_early_read); // R3

    AST_DP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(vld[0] && cls0 == 3'd5) && vld[0] && unit0 == $past(unit0))
        |=> haz_unit_busy); // R7

    AST_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (vld[1:0] == 2'b11 && den == 2'b11 && cls0 != 3'd4 && cls1 != 3'd4 && dst0 == dst1)
        |=> haz_dual_write); // R10

    AST_CROSS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (vld[2:0] == 3'b111 && s_en == 3'b111 && src_bank == ~unit_side)
        |=> haz_cross_limit); // R9

endmodule

bind hz_scoreboard hz_scoreboard_sva #(
    .LANES  (LANES),
    .REG_W  (REG_W),
    .UNIT_W (UNIT_W)
) u_sva (
    .clk             (clk),
    .rst_n           (rst_n),
    .vld             (op_vld),
    .cls0            (op_cls[2:0]),
    .cls1            (op_cls[5:3]),
    .dst0            (op_dst[REG_W-1:0]),
    .dst1            (op_dst[2*REG_W-1:REG_W]),
    .den             (op_dst_en[1:0]),
    .src0_l0         (op_src0[REG_W-1:0]),
    .s_en            (op_src0_en[2:0]),
    .src_bank        ({op_src0[3*REG_W-1], op_src0[2*REG_W-1], op_src0[REG_W-1]}),
    .unit0           (op_unit[UNIT_W-1:0]),
    .unit_side       ({op_unit[3*UNIT_W-1], op_unit[2*UNIT_W-1], op_unit[UNIT_W-1]}),
    .haz_early_read  (haz_early_read),
    .haz_unit_busy   (haz_unit_busy),
    .haz_unit_clash  (haz_unit_clash),
    .haz_dual_write  (haz_dual_write),
    .haz_cross_limit (haz_cross_limit)
);

// File: tb/sim_hz_scoreboard.sv
`timescale 1ns/1ps
// Bench for hz_scoreboard: sweeps class against read distance, class against
// re-issue distance, all lane pairs for clashes and dual writes, and every
// count of cross-bank reads.
module sim_hz_scoreboard;

    localparam int L  = 8;
    localparam int RW = 5;
    localparam int UW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [L-1:0]    op_vld;
    logic [L*3-1:0]  op_cls;
    logic [L*RW-1:0] op_dst;
    logic [L-1:0]    op_dst_en;
    logic [L*RW-1:0] op_src0;
    logic [L-1:0]    op_src0_en;
    logic [L*RW-1:0] op_src1;
    logic [L-1:0]    op_src1_en;
    logic [L*UW-1:0] op_unit;
    logic            haz_early_read;
    logic [RW-1:0]   early_reg;
    logic            haz_unit_busy;
    logic [UW-1:0]   busy_unit;
    logic            haz_unit_clash;
    logic [UW-1:0]   clash_unit;
    logic            haz_dual_write;
    logic [RW-1:0]   dual_reg;
    logic            haz_cross_limit;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    hz_scoreboard u0 (
        .clk(clk), .rst_n(rst_n),
        .op_vld(op_vld), .op_cls(op_cls), .op_dst(op_dst), .op_dst_en(op_dst_en),
        .op_src0(op_src0), .op_src0_en(op_src0_en), .op_src1(op_src1), .op_src1_en(op_src1_en),
        .op_unit(op_unit),
        .haz_early_read(haz_early_read), .early_reg(early_reg),
        .haz_unit_busy(haz_unit_busy), .busy_unit(busy_unit),
        .haz_unit_clash(haz_unit_clash), .clash_unit(clash_unit),
        .haz_dual_write(haz_dual_write), .dual_reg(dual_reg),
        .haz_cross_limit(haz_cross_limit)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_all();
        op_vld = '0; op_cls = '0; op_dst = '0; op_dst_en = '0;
        op_src0 = '0; op_src0_en = '0; op_src1 = '0; op_src1_en = '0; op_unit = '0;
    endtask

    task automatic set_lane(input int l, input int cls, input int dst, input bit den,
                            input int s0, input bit s0en, input int s1, input bit s1en,
                            input int unit);
        op_vld[l]           = 1'b1;
        op_cls[l*3 +: 3]    = 3'(cls);
        op_dst[l*RW +: RW]  = RW'(dst);
        op_dst_en[l]        = den;
        op_src0[l*RW +: RW] = RW'(s0);
        op_src0_en[l]       = s0en;
        op_src1[l*RW +: RW] = RW'(s1);
        op_src1_en[l]       = s1en;
        op_unit[l*UW +: UW] = UW'(unit);
    endtask

    // Present the current inputs for one clock; outputs then describe them.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        clear_all();
        repeat (n) tick();
    endtask

    function automatic int slots_of(input int cls);
        case (cls)
            1: return 1;
            2: return 4;
            3: return 5;
            5: return 9;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input int cls);
        case (cls)
            0: return "R2";
            1: return "R3";
            2, 3: return "R4";
            5: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        clear_all();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: outputs quiet after reset; every register readable.
        check("R1 early", int'(haz_early_read), 0);
        check("R1 busy", int'(haz_unit_busy), 0);
        check("R1 dual", int'(haz_dual_write), 0);
        for (int p = 0; p < 4; p++) begin
            clear_all();
            for (int i = 0; i < 8; i++) begin
                set_lane(i, 0, 0, 1'b0, (i / 4) * 16 + p * 4 + (i % 4), 1'b1, 0, 1'b0, i);
            end
            tick();
            check("R1 ready after reset", int'(haz_early_read), 0);
            check("R1 no cross", int'(haz_cross_limit), 0);
        end
        idle(2);

        // R2..R6: class against read distance.
        for (int c = 0; c < 6; c++) begin
            for (int k = 1; k <= 11; k++) begin
                int r;
                bit exp;
                r = k;
                clear_all();
                set_lane(0, c, r, 1'b1, 0, 1'b0, 0, 1'b0, 0);
                tick();
                idle(k - 1);
                set_lane(3, 0, 0, 1'b0, 0, 1'b0, r, 1'b1, 3);
                tick();
                exp = (c != 4) && (k <= slots_of(c));
                check(req_of(c), int'(haz_early_read), int'(exp));
                if (exp) check("R11 early_reg", int'(early_reg), r);
                idle(12);
            end
        end

        // R6: two stores to one destination are not a dual write.
        clear_all();
        set_lane(0, 4, 9, 1'b1, 0, 1'b0, 0, 1'b0, 0);
        set_lane(1, 4, 9, 1'b1, 0, 1'b0, 0, 1'b0, 1);
        tick();
        check("R6 store dual", int'(haz_dual_write), 0);
        idle(12);

        // R7: class against re-issue distance on units 2 and 6.
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 6; c++) begin
                for (int k = 1; k <= 5; k++) begin
                    int u;
                    bit exp;
                    u = 2 + 4 * s;
                    clear_all();
                    set_lane(0, c, 0, 1'b0, 0, 1'b0, 0, 1'b0, u);
                    tick();
                    idle(k - 1);
                    set_lane(0, 0, 0, 1'b0, 0, 1'b0, 0, 1'b0, u);
                    tick();
                    exp = (c == 5) && (k <= 3);
                    check("R7 busy", int'(haz_unit_busy), int'(exp));
                    if (exp) check("R7 busy_unit", int'(busy_unit), u);
                    idle(6);
                end
            end
        end

        // R7: back-to-back short issues must not cut a running hold.
        clear_all();
        set_lane(0, 5, 0, 1'b0, 0, 1'b0, 0, 1'b0, 2);
        tick();
        for (int k = 1; k <= 4; k++) begin
            clear_all();
            set_lane(0, 0, 0, 1'b0, 0, 1'b0, 0, 1'b0, 2);
            tick();
            check("R7 hold kept", int'(haz_unit_busy), int'(k <= 3));
        end
        idle(6);

        // R8: every lane pair on one unit; then all distinct.
        for (int i = 0; i < 8; i++) begin
            for (int j = i + 1; j < 8; j++) begin
                clear_all();
                set_lane(i, 0, 0, 1'b0, 0, 1'b0, 0, 1'b0, 5);
                set_lane(j, 0, 0, 1'b0, 0, 1'b0, 0, 1'b0, 5);
                tick();
                check("R8 clash", int'(haz_unit_clash), 1);
                check("R8 clash_unit", int'(clash_unit), 5);
            end
        end
        clear_all();
        for (int i = 0; i < 8; i++) set_lane(i, 0, 0, 1'b0, 0, 1'b0, 0, 1'b0, i);
        tick();
        check("R8 no clash", int'(haz_unit_clash), 0);
        idle(2);

        // R10: every lane pair writing register 7.
        for (int i = 0; i < 8; i++) begin
            for (int j = i + 1; j < 8; j++) begin
                clear_all();
                set_lane(i, 0, 7, 1'b1, 0, 1'b0, 0, 1'b0, i);
                set_lane(j, 0, 7, 1'b1, 0, 1'b0, 0, 1'b0, j);
                tick();
                check("R10 dual", int'(haz_dual_write), 1);
                check("R10 dual_reg", int'(dual_reg), 7);
            end
        end
        // R10: lowest repeating lane picks the reported register.
        clear_all();
        set_lane(0, 0, 20, 1'b1, 0, 1'b0, 0, 1'b0, 0);
        set_lane(1, 0, 11, 1'b1, 0, 1'b0, 0, 1'b0, 1);
        set_lane(2, 0, 11, 1'b1, 0, 1'b0, 0, 1'b0, 2);
        set_lane(5, 0, 20, 1'b1, 0, 1'b0, 0, 1'b0, 5);
        tick();
        check("R10 lowest dual_reg", int'(dual_reg), 11);
        idle(2);

        // R9: number of cross-bank reads from 0 to 8.
        for (int n = 0; n <= 8; n++) begin
            clear_all();
            for (int i = 0; i < 8; i++) begin
                int side;
                side = i / 4;
                if (i < n) set_lane(i, 0, 0, 1'b0, (1 - side) * 16 + i, 1'b1, 0, 1'b0, i);
                else       set_lane(i, 0, 0, 1'b0, side * 16 + i, 1'b1, 0, 1'b0, i);
            end
            tick();
            check("R9 cross", int'(haz_cross_limit), int'(n > 2));
        end
        idle(2);

        // R12: reading in the writer's own packet, then one packet later.
        clear_all();
        set_lane(0, 2, 5, 1'b1, 0, 1'b0, 0, 1'b0, 0);
        set_lane(1, 0, 0, 1'b0, 5, 1'b1, 0, 1'b0, 1);
        tick();
        check("R12 same packet", int'(haz_early_read), 0);
        clear_all();
        set_lane(1, 0, 0, 1'b0, 5, 1'b1, 0, 1'b0, 1);
        tick();
        check("R12 next packet", int'(haz_early_read), 1);
        idle(12);

        // R11: lowest lane reported, source 0 before source 1.
        clear_all();
        set_lane(0, 2, 4, 1'b1, 0, 1'b0, 0, 1'b0, 0);
        set_lane(1, 2, 9, 1'b1, 0, 1'b0, 0, 1'b0, 1);
        tick();
        clear_all();
        set_lane(2, 0, 0, 1'b0, 9, 1'b1, 4, 1'b1, 2);
        set_lane(5, 0, 0, 1'b0, 4, 1'b1, 0, 1'b0, 5);
        tick();
        check("R11 early_reg lowest", int'(early_reg), 9);
        idle(12);

        // R1: reset mid-run clears a pending register and a held unit.
        clear_all();
        set_lane(0, 5, 3, 1'b1, 0, 1'b0, 0, 1'b0, 2);
        tick();
        clear_all();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        set_lane(0, 0, 0, 1'b0, 3, 1'b1, 0, 1'b0, 2);
        tick();
        check("R1 reset clears slot", int'(haz_early_read), 0);
        check("R1 reset clears hold", int'(haz_unit_busy), 0);
        idle(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule